// File: doc/BRIEF.md
# Asynchronous SRAM port decoder

This block is a clock-sampled model of the pin-level port of an asynchronous static RAM that is organised as either 8-bit bytes or 16-bit words. On every rising clock edge it samples active-low chip enable, output enable, write enable, the two byte enables and an active-low store-busy line. It also samples an active-high inhibit input that comes from a nonvolatile-transfer sequencer. From these it classifies the cycle as a read, a write or idle, and runs that cycle against an internal array. The analog access times are modelled as two parameters that count cycles: `READ_LAT` from a qualified read to valid data, and `WHZ_LAT` from the fall of write enable to the output drivers turning off.

The controller is a five-state machine. `IDLE` waits. A qualified read moves it to `RD_WAIT`, which counts the access delay and restarts the count whenever the address moves. It then moves to `RD_VALID`, which drives the data. A qualified write from any of these moves it to `WRITE`. That state latches address, data and byte mask on every qualified edge and commits them on the edge where chip enable or write enable is seen high. From `WRITE` it moves to `RD_WAIT` when a read is qualified at that same edge, and to `IDLE` otherwise. An active inhibit from any state moves it to `BLOCKED`, which returns to `IDLE` once the inhibit clears. Losing read qualification returns the machine to `IDLE`.

Top module: `sram_port_ctrl`

## Requirements
- R1: A read is qualified only while ce_n=0, oe_n=0, we_n=1, busy_n=1 and xfer_inhibit=0. Data appears on the READ_LAT-th rising edge after the first edge that sees the read qualified at an address. At the edges before that, the outputs stay undriven.
- R2: A write is qualified only while ce_n=0, we_n=0, busy_n=1 and xfer_inhibit=0. It commits on the first edge that sees ce_n or we_n high, provided busy_n=1 and xfer_inhibit=0 at that edge. The commit uses the address, data and byte enables from the last qualified edge. A read that becomes qualified on that same edge returns the new data.
- R3: On reads, dout_en[0] is the inverse of lb_n and governs dout[7:0], and dout_en[1] is the inverse of ub_n and governs dout[15:8]. A byte-enable change while reading takes effect at the next edge.
- R4: On writes, a byte is updated only if its enable (lb_n for bits 7:0, ub_n for bits 15:8) was low. The other byte keeps its old content.
- R5: If the address changes while a read stays qualified, the outputs go undriven at the next edge. The new word then appears READ_LAT edges after that edge, with no control-pin transition needed.
- R6: A read ends, with all outputs undriven at the next edge, when ce_n or oe_n rises or busy_n falls.
- R7: If a write starts while read data is being driven, the outputs keep their value for WHZ_LAT edges, counting the edge that first sees we_n low, and are undriven at the edge after those.
- R8: While xfer_inhibit=1, the outputs are undriven from the next edge on and no write commits. This holds for writes attempted during the inhibit and for a write that the inhibit interrupts.
- R9: After reset, and for every undriven byte, dout_en for that byte is 0 and its dout bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper-byte enable, active low (unused for 8-bit width) |
| lb_n | input | 1 | Lower-byte enable, active low |
| busy_n | input | 1 | Store-busy line, low while a store runs |
| xfer_inhibit | input | 1 | High while a store or recall transfer runs |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero where not driven |
| dout_en | output | DATA_W/8 | Per-byte output-drive indication |

## Verification
Two functions can fall on the same edge. One is the end of a write, when the array is updated. The other is the start of a read at the same address, which can be qualified by that same edge. The bench provokes this by raising only we_n while ce_n and oe_n stay low. It expects undriven outputs at that edge and the freshly written word READ_LAT edges later, never the old contents. A second overlap is an inhibit that rises on the very edge a write ends. In that case the bench reads the word back afterwards and expects its old value.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_WAIT,
        S_RD_VALID,
        S_WRITE,
        S_BLOCKED
    } port_state_e;

endpackage

// File: rtl/sram_port_decode.sv
module sram_port_decode #(
    parameter int BYTES = 2
) (
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             ub_n,
    input  logic             lb_n,
    input  logic             busy_n,
    input  logic             xfer_inhibit,
    output logic             rd_q,
    output logic             wr_q,
    output logic             wr_end_ok,
    output logic [BYTES-1:0] be_n_vec
);

    // Qualified cycle types
    assign rd_q      = !ce_n && !oe_n && we_n && busy_n && !xfer_inhibit;
    assign wr_q      = !ce_n && !we_n && busy_n && !xfer_inhibit;
    // A write may close (and commit) only on a clean release edge
    assign wr_end_ok = (ce_n || we_n) && busy_n && !xfer_inhibit;

    generate
        if (BYTES == 1) begin : g_narrow
            assign be_n_vec = lb_n;
        end else begin : g_wide
            assign be_n_vec = {ub_n, lb_n};
        end
    endgenerate

endmodule

// File: rtl/sram_port_array.sv
module sram_port_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] bwe,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int BYTES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            logic [7:0] lane [DEPTH];
            always_ff @(posedge clk) begin
                if (bwe[b]) begin
                    lane[wr_addr] <= wr_data[b*8 +: 8];
                end
            end
            assign rd_data[b*8 +: 8] = lane[rd_addr];
        end
    endgenerate

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int READ_LAT = 2,
    parameter int WHZ_LAT  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                we_n,
    input  logic                ub_n,
    input  logic                lb_n,
    input  logic                busy_n,
    input  logic                xfer_inhibit,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic [DATA_W/8-1:0] dout_en
);

    localparam int BYTES = DATA_W / 8;
    localparam int MAXL  = (READ_LAT > WHZ_LAT) ? READ_LAT : WHZ_LAT;
    localparam int CNT_W = $clog2(MAXL + 1);
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(READ_LAT - 1);
    localparam logic [CNT_W-1:0] WHZ_LOAD = CNT_W'(WHZ_LAT - 1);

    port_state_e       state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [ADDR_W-1:0] addr_lat;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [BYTES-1:0]  wr_mask;
    logic [BYTES-1:0]  bwe;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] dout_n;
    logic [BYTES-1:0]  en_n;
    logic              rd_q, wr_q, wr_end_ok;
    logic [BYTES-1:0]  be_n_vec;
    logic              addr_moved;

    sram_port_decode #(.BYTES(BYTES)) u_decode (
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .ub_n        (ub_n),
        .lb_n        (lb_n),
        .busy_n      (busy_n),
        .xfer_inhibit(xfer_inhibit),
        .rd_q        (rd_q),
        .wr_q        (wr_q),
        .wr_end_ok   (wr_end_ok),
        .be_n_vec    (be_n_vec)
    );

    sram_port_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bwe    (bwe),
        .rd_addr(addr_lat),
        .rd_data(rd_data)
    );

    assign addr_moved = (addr != addr_lat);
    assign bwe        = (state == S_WRITE && wr_end_ok) ? wr_mask : '0;

    // Next-state decision
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            S_IDLE, S_BLOCKED: begin
                if (xfer_inhibit)  state_n = S_BLOCKED;
                else if (wr_q)     begin state_n = S_WRITE;   cnt_n = WHZ_LOAD; end
                else if (rd_q)     begin state_n = S_RD_WAIT; cnt_n = RD_LOAD;  end
                else               state_n = S_IDLE;
            end
            S_RD_WAIT: begin
                if (xfer_inhibit)    state_n = S_BLOCKED;
                else if (wr_q)       begin state_n = S_WRITE; cnt_n = WHZ_LOAD; end
                else if (!rd_q)      state_n = S_IDLE;
                else if (addr_moved) cnt_n = RD_LOAD;
                else if (cnt == '0)  state_n = S_RD_VALID;
                else                 cnt_n = cnt - 1'b1;
            end
            S_RD_VALID: begin
                if (xfer_inhibit)    state_n = S_BLOCKED;
                else if (wr_q)       begin state_n = S_WRITE;   cnt_n = WHZ_LOAD; end
                else if (!rd_q)      state_n = S_IDLE;
                else if (addr_moved) begin state_n = S_RD_WAIT; cnt_n = RD_LOAD;  end
            end
            S_WRITE: begin
                if (xfer_inhibit) state_n = S_BLOCKED;
                else if (wr_q)    begin if (cnt != '0) cnt_n = cnt - 1'b1; end
                else if (rd_q)    begin state_n = S_RD_WAIT; cnt_n = RD_LOAD; end
                else              state_n = S_IDLE;
            end
        endcase
    end

    // State register and cycle latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            addr_lat <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_mask  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (state_n == S_RD_WAIT) addr_lat <= addr;
            if (wr_q) begin
                wr_addr <= addr;
                wr_data <= din;
                wr_mask <= ~be_n_vec;
            end
        end
    end

    // Output decode
    always_comb begin
        en_n   = '0;
        dout_n = '0;
        unique case (state_n)
            S_RD_VALID: begin
                en_n = ~be_n_vec;
                for (int b = 0; b < BYTES; b++) begin
                    dout_n[b*8 +: 8] = en_n[b] ? rd_data[b*8 +: 8] : 8'h00;
                end
            end
            S_WRITE: begin
                if (!(state == S_WRITE && cnt == '0)) begin
                    en_n   = dout_en;
                    dout_n = dout;
                end
            end
            S_IDLE, S_RD_WAIT, S_BLOCKED: begin
                en_n   = '0;
                dout_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= '0;
        end else begin
            dout    <= dout_n;
            dout_en <= en_n;
        end
    end

    // Checks
    assert_rd_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dout_en) |-> $past(rd_q));

    assert_commit_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|bwe) |-> $past(wr_q));

    assert_byte_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_VALID) |-> ((dout_en & $past(be_n_vec)) == '0));

    assert_hiz_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE && cnt == '0) |=> (dout_en == '0));

    assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_inhibit |=> (dout_en == '0));

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_idle_chk
            assert_idle_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !dout_en[b] |-> (dout[b*8 +: 8] == 8'h00));
        end
    endgenerate

endmodule

// File: tb/sram_port_ctrl_tb.sv
module sram_port_ctrl_tb;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int RL = 2;
    localparam int WZ = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, ce_n, oe_n, we_n, ub_n, lb_n, busy_n, inh;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    logic [1:0] dout_en;

    sram_port_ctrl #(.ADDR_W(AW), .DATA_W(DW), .READ_LAT(RL), .WHZ_LAT(WZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .ub_n(ub_n), .lb_n(lb_n), .busy_n(busy_n), .xfer_inhibit(inh),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct {
        int          at;
        logic [1:0]  en;
        logic [15:0] d;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [15:0] model [64];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops due items and compares them with the ports
    always @(negedge clk) begin : mon
        exp_t e;
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            e = sbq.pop_front();
            checks++;
            if (dout_en !== e.en || dout !== e.d) begin
                fails++;
                $display("FAIL %s: en=%b dout=%h expected en=%b dout=%h",
                         e.tag, dout_en, dout, e.en, e.d);
            end
        end
    end

    task automatic expect_at(int n, logic [1:0] en, logic [15:0] d, string tag);
        exp_t e;
        e.at = cyc + n; e.en = en; e.d = d; e.tag = tag;
        sbq.push_back(e);
    endtask

    function automatic logic [15:0] masked(logic [15:0] w, logic [1:0] en);
        return {en[1] ? w[15:8] : 8'h00, en[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic do_write(int a, logic [15:0] d, logic ub, logic lb, bit lands);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); din = d; ub_n = ub; lb_n = lb;
        @(negedge clk);
        we_n = 1; ce_n = 1;
        @(negedge clk);
        if (lands) begin
            if (!ub) model[a][15:8] = d[15:8];
            if (!lb) model[a][7:0]  = d[7:0];
        end
    endtask

    task automatic do_read(int a, logic ub, logic lb, string tag);
        logic [1:0] en;
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a); ub_n = ub; lb_n = lb;
        en = ~{ub, lb};
        expect_at(1, 2'b00, 16'h0000, {tag, " (still waiting)"});
        expect_at(1 + RL, en, masked(model[a], en), tag);
        repeat (1 + RL) @(negedge clk);
    endtask

    task automatic rd_stop();
        @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1; ub_n = 0; lb_n = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 16'h0000;
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; ub_n = 0; lb_n = 0;
        busy_n = 1; inh = 0; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        expect_at(1, 2'b00, 16'h0000, "R9 reset state");
        @(negedge clk);

        do_write(3, 16'hA5C3, 0, 0, 1);
        do_write(5, 16'h1234, 0, 0, 1);
        do_read(3, 0, 0, "R1 read latency");
        do_read(5, 0, 0, "R5 address follow");

        // R3 / R9: byte lanes while reading
        @(negedge clk); ub_n = 1;
        expect_at(1, 2'b01, 16'h0034, "R3 low byte only, R9 idle upper");
        @(negedge clk); ub_n = 0; lb_n = 1;
        expect_at(1, 2'b10, 16'h1200, "R3 high byte only");
        @(negedge clk); lb_n = 0;
        // R6: oe rise
        @(negedge clk); oe_n = 1;
        expect_at(1, 2'b00, 16'h0000, "R6 oe rise");
        rd_stop();
        do_read(5, 0, 0, "R1 read");
        @(negedge clk); busy_n = 0;
        expect_at(1, 2'b00, 16'h0000, "R6 busy fall");
        @(negedge clk); busy_n = 1;
        rd_stop();
        do_read(3, 0, 0, "R1 read");
        @(negedge clk); ce_n = 1;
        expect_at(1, 2'b00, 16'h0000, "R6 ce rise");
        rd_stop();

        // R4: masked write of upper byte
        do_write(3, 16'hFFFF, 0, 1, 1);
        do_read(3, 0, 0, "R4 masked write");

        // R7: write while outputs driven, then R2 collision with a read start
        @(negedge clk); we_n = 0; din = 16'h0F0F;
        expect_at(1, 2'b11, 16'hFFC3, "R7 held at first write edge");
        expect_at(WZ, 2'b11, 16'hFFC3, "R7 held through delay");
        expect_at(1 + WZ, 2'b00, 16'h0000, "R7 off after delay");
        repeat (1 + WZ) @(negedge clk);
        we_n = 1; model[3] = 16'h0F0F;
        expect_at(1, 2'b00, 16'h0000, "R2 write end starts read wait");
        expect_at(1 + RL, 2'b11, 16'h0F0F, "R2 read sees committed data");
        repeat (1 + RL) @(negedge clk);
        rd_stop();

        // R8: inhibit blocks reads and writes
        do_read(5, 0, 0, "R1 read");
        @(negedge clk); inh = 1;
        expect_at(1, 2'b00, 16'h0000, "R8 read blocked");
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; addr = 5; din = 16'hDEAD;
        expect_at(1, 2'b00, 16'h0000, "R8 outputs quiet");
        @(negedge clk); we_n = 1; ce_n = 1;
        @(negedge clk); inh = 0;
        @(negedge clk);
        do_read(5, 0, 0, "R8 write during inhibit ignored");
        rd_stop();

        @(negedge clk); ce_n = 0; we_n = 0; addr = 5; din = 16'hBEEF;
        @(negedge clk); inh = 1; we_n = 1; ce_n = 1;
        @(negedge clk); inh = 0;
        @(negedge clk);
        do_read(5, 0, 0, "R8 interrupted write not committed");
        rd_stop();

        // R2: busy low disqualifies a write
        @(negedge clk); busy_n = 0; ce_n = 0; we_n = 0; addr = 3; din = 16'h5555;
        @(negedge clk); we_n = 1; ce_n = 1;
        @(negedge clk); busy_n = 1;
        @(negedge clk);
        do_read(3, 0, 0, "R2 write with busy low ignored");
        rd_stop();

        repeat (4) @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard drain: pending=%0d expected=0", sbq.size());
        end
        finish_run();
    end

endmodule